// File: doc/BRIEF.md
# Transmit-Only Serial Array Streamer

This block feeds a small byte array, one bit at a time, onto an open-drain data line. It is paced only by a slow transmit clock from outside, and the host needs no protocol to receive the data. After reset the line is left released for a synchronisation preamble. The block then sends every byte of the array in rising address order, most significant bit first. Each byte is followed by a released null bit. After the last location the address wraps to the first and streaming goes on with no gap.

A second, bidirectional clock line is watched for as long as streaming lasts. A high-to-low transition on that line is valid only if the line was first seen high after reset. Such a transition ends streaming for good: the block releases the data line, raises a mode flag so that a two-wire slave can take the line over, and from then on passes the transmit clock level on as a write enable. Only a reset brings the block back to streaming.

Both clock inputs are asynchronous. They are synchronised to the system clock, and their edges are detected in that domain. The array is read through a combinational read port.

Top module: `sas_stream_top`

## Requirements
- R1: During and just after reset, `sda_oe_o`, `bidir_mode_o` and `wr_en_o` are 0, and `rd_addr_o` equals the START_ADDR parameter (default 0).
- R2: For the first nine rising edges of `tx_clk_i` after reset, `sda_oe_o` stays 0 (line released).
- R3: The tenth rising edge of `tx_clk_i` presents the most significant bit of the byte at START_ADDR. `sda_oe_o` changes only after a rising edge of `tx_clk_i` or a valid falling edge of `bus_scl_i`.
- R4: The bits of a byte go out most significant first, one per rising edge. A 0 bit drives `sda_oe_o`=1 (pull low) and a 1 bit drives `sda_oe_o`=0 (released).
- R5: After the eight data bits, a ninth null bit keeps `sda_oe_o`=0 for one transmit clock period.
- R6: Bytes are sent in increasing address order. After address DEPTH-1 the next byte is address 0, with no extra gap.
- R7: While `bus_scl_i` stays high, streaming continues. A falling edge on `bus_scl_i`, after it has been seen high, sets `bidir_mode_o`=1 and forces `sda_oe_o`=0 within four system clock cycles, even in the middle of a byte.
- R8: Once set, `bidir_mode_o` stays 1 whatever `bus_scl_i` does afterwards. Only reset clears it.
- R9: In bidirectional mode, `tx_clk_i` has no effect on `sda_oe_o`, and `wr_en_o` follows the synchronised level of `tx_clk_i` (1 allows writes). In transmit-only mode, `wr_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_clk_i | input | 1 | Asynchronous transmit clock; each rising edge advances one bit |
| bus_scl_i | input | 1 | Asynchronous bidirectional bus clock; a valid falling edge ends streaming |
| rd_data_i | input | DATA_W (8) | Byte read from the array at `rd_addr_o` (combinational read) |
| rd_addr_o | output | ADDR_W (7) | Array read address |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line (1 = drive low) |
| bidir_mode_o | output | 1 | 1 once the block has handed the line to the bidirectional slave |
| wr_en_o | output | 1 | Write enable for bidirectional mode (synchronised transmit clock level) |

## Verification
The array is filled with a computed pattern that mixes set and clear bits, and the stream is compared bit by bit for more than a full pass. This separates errors in bit order, in the placement of the null bit, in the preamble length and in the address wrap. The bus clock is then dropped while a pulled-low bit is on the line. This shows whether the line is released at once rather than at the next frame. Further transmit clock pulses and bus clock toggles in bidirectional mode must not move the data line, while the write enable follows the transmit clock level. A final reset checks that the preamble and the first byte are replayed from the start address.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_BITS  = 2'd1,
    PH_GAP   = 2'd2,
    PH_BIDIR = 2'd3
  } sas_phase_e;
endpackage

// File: rtl/sas_sync.sv
module sas_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b0,
  parameter bit EDGE_RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      last_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];

  generate
    if (EDGE_RISE) begin : g_rise
      assign edge_o = level_o & ~last_q;
    end else begin : g_fall
      assign edge_o = ~level_o & last_q;
    end
  endgenerate

  // R3: an edge is a single-cycle event
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/sas_frame_seq.sv
module sas_frame_seq
  import sas_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 128,
  parameter int ADDR_W     = $clog2(DEPTH),
  parameter int PRE_EDGES  = 9,
  parameter int START_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              halt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              pull_o,
  output logic              bidir_o
);
  localparam int CNT_W = $clog2(PRE_EDGES + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  PRE_LAST = CNT_W'(PRE_EDGES);
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] ADDR_RST = ADDR_W'(START_ADDR);

  sas_phase_e        phase_q;
  logic [CNT_W-1:0]  pre_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return (a == ADDR_TOP) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PRE;
      pre_q   <= '0;
      bit_q   <= '0;
      shift_q <= '1;
      addr_q  <= ADDR_RST;
    end else if (halt_i) begin
      phase_q <= PH_BIDIR;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_PRE: begin
          if (pre_q == PRE_LAST) begin
            phase_q <= PH_BITS;
            bit_q   <= '0;
            shift_q <= rd_data_i;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        PH_BITS: begin
          if (bit_q == BIT_LAST) begin
            phase_q <= PH_GAP;
            addr_q  <= addr_next(addr_q);
          end else begin
            bit_q   <= bit_q + 1'b1;
            shift_q <= {shift_q[DATA_W-2:0], 1'b1};
          end
        end
        PH_GAP: begin
          phase_q <= PH_BITS;
          bit_q   <= '0;
          shift_q <= rd_data_i;
        end
        default: phase_q <= PH_BIDIR;
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign bidir_o   = (phase_q == PH_BIDIR);
  assign pull_o    = (phase_q == PH_BITS) & ~shift_q[DATA_W-1];

  // R3: the line moves only after a transmit edge or a mode switch
  a_r3_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !halt_i) |=> $stable(pull_o));

  // R6: the address only ever steps forward by one, wrapping at the top
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_o != $past(rd_addr_o)) |-> (rd_addr_o == addr_next($past(rd_addr_o))));

  // R8: bidirectional mode is sticky
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidir_o |=> bidir_o);
endmodule

// File: rtl/sas_stream_top.sv
module sas_stream_top #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 128,
  parameter int ADDR_W      = $clog2(DEPTH),
  parameter int PRE_EDGES   = 9,
  parameter int SYNC_STAGES = 2,
  parameter int START_ADDR  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_clk_i,
  input  logic              bus_scl_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sda_oe_o,
  output logic              bidir_mode_o,
  output logic              wr_en_o
);
  localparam int NSYNC = 2;
  // index 0: transmit clock (rising), index 1: bus clock (falling)
  localparam logic [NSYNC-1:0] SYNC_RST  = 2'b01;
  localparam logic [NSYNC-1:0] SYNC_RISE = 2'b01;

  logic [NSYNC-1:0] async_in, sync_lvl, sync_edge;
  logic             pull, bidir;

  assign async_in = {bus_scl_i, tx_clk_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    sas_sync #(
      .STAGES   (SYNC_STAGES),
      .RST_VAL  (SYNC_RST[g]),
      .EDGE_RISE(SYNC_RISE[g])
    ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(async_in[g]),
      .level_o(sync_lvl[g]),
      .edge_o (sync_edge[g])
    );
  end

  sas_frame_seq #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .PRE_EDGES (PRE_EDGES),
    .START_ADDR(START_ADDR)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (sync_edge[0]),
    .halt_i   (sync_edge[1]),
    .rd_data_i(rd_data_i),
    .rd_addr_o(rd_addr_o),
    .pull_o   (pull),
    .bidir_o  (bidir)
  );

  assign sda_oe_o     = pull & ~bidir;
  assign bidir_mode_o = bidir;
  assign wr_en_o      = bidir & sync_lvl[0];

  // R7: a bus clock seen high keeps streaming for the next cycle
  a_r7_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl[1] && !bidir_mode_o) |=> !bidir_mode_o);

  // R7: once handed over, the line is never pulled by the streamer
  a_r7_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidir_mode_o |-> !sda_oe_o);

  // R9: no write enable while streaming
  a_r9_wr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bidir_mode_o |-> !wr_en_o);
endmodule

// File: tb/tb_sas_stream_top.sv
module tb_sas_stream_top;
  localparam int CLK_P   = 10;
  localparam int TX_HALF = 10;
  localparam int DEPTH   = 128;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_clk = 1'b0;
  logic       scl = 1'b1;
  logic [7:0] rd_data;
  logic [6:0] rd_addr;
  logic       sda_oe, bidir, wr_en;

  logic [7:0] mem [DEPTH];
  bit         exp_q[$];
  string      tag_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rd_data = mem[rd_addr];

  sas_stream_top dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tx_clk_i    (tx_clk),
    .bus_scl_i   (scl),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .sda_oe_o    (sda_oe),
    .bidir_mode_o(bidir),
    .wr_en_o     (wr_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one transmit clock period, expected line state queued at the rise
  task automatic tx_cycle(input bit exp_oe, input string tag);
    @(negedge clk);
    tx_clk = 1'b1;
    exp_q.push_back(exp_oe);
    tag_q.push_back(tag);
    repeat (TX_HALF) @(negedge clk);
    tx_clk = 1'b0;
    repeat (TX_HALF) @(negedge clk);
  endtask

  // monitor: compare in the middle of each transmit period
  always @(negedge tx_clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'(sda_oe), int'(e));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 29 + 7) ^ (i >> 3));

    repeat (5) @(negedge clk);
    check("R1 oe", int'(sda_oe), 0);
    check("R1 mode", int'(bidir), 0);
    check("R1 wr", int'(wr_en), 0);
    check("R1 addr", int'(rd_addr), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 oe after release", int'(sda_oe), 0);

    for (int i = 0; i < 9; i++) tx_cycle(1'b0, "R2 preamble");

    for (int k = 0; k < DEPTH + 2; k++) begin
      int a;
      a = k % DEPTH;
      for (int b = 7; b >= 0; b--) begin
        if (k == 0 && b == 7)  tx_cycle(!mem[a][b], "R3 first msb");
        else if (k >= DEPTH)   tx_cycle(!mem[a][b], "R6 wrapped byte");
        else                   tx_cycle(!mem[a][b], "R4 data bit");
      end
      tx_cycle(1'b0, "R5 null bit");
    end
    check("R7 stays streaming with bus clock high", int'(bidir), 0);

    // msb of mem[2] is 0: line pulled when the bus clock drops
    tx_cycle(!mem[2][7], "R4 pulled bit");
    check("R7 pulled before switch", int'(sda_oe), 1);
    @(negedge clk);
    scl = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 mode set", int'(bidir), 1);
    check("R7 line released", int'(sda_oe), 0);

    for (int i = 0; i < 3; i++) tx_cycle(1'b0, "R9 tx clock ignored");
    tx_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 wr follows high", int'(wr_en), 1);
    check("R9 line still released", int'(sda_oe), 0);
    tx_clk = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 wr follows low", int'(wr_en), 0);

    scl = 1'b1;
    repeat (4) @(negedge clk);
    scl = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 mode sticky", int'(bidir), 1);
    tx_cycle(1'b0, "R8 no streaming after toggles");

    rst_ni = 1'b0;
    scl = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset clears mode", int'(bidir), 0);
    check("R1 addr after reset", int'(rd_addr), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) tx_cycle(1'b0, "R2 preamble again");
    tx_cycle(!mem[0][7], "R3 restart msb");
    tx_cycle(!mem[0][6], "R4 restart bit6");
    tx_cycle(!mem[0][5], "R4 restart bit5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule